// File: doc/BRIEF.md
# Misaligned Access Exception Controller

This block sits beside a processor pipeline and watches every memory access it makes. An instruction fetch, a word operand or a long-word operand whose address is not word aligned raises an address-error exception request. The request follows the same handling path as a bus error, and only the vector it selects is different. Byte accesses are exempt. Each access is presented at the point where the pipeline uses its result, so a fault on an ordinary access is reported as soon as the faulting value would be consumed.

Two kinds of fault are deferred. The first is a write that has already been handed off to the bus ("released"). The second is a taken branch whose target is odd. The first is reported when the pipeline next reaches an instruction boundary or next attempts an operand access. The second is reported when the program counter is actually loaded with the target. A single slot holds the deferred fault.

A fault that shows up while the processor is already handling a bus-error, address-error or reset exception does not nest. The block asserts a halt output instead, and that output stays asserted until the next reset. The bus interface, stack frame writing and vector fetch are handled outside this block.

Top module: `misalign_exc_ctrl`

## Requirements
- R1: An access with `acc_valid` high and kind fetch (1), word (3) or long (4) at an odd address, that is not a released write, gives `exc_req` high in the following cycle. In that cycle `fault_addr` equals the access address, and `ret_pc` and `instr_pc` both equal `acc_pc`.
- R2: A byte access (kind 2) never faults, whatever its address. An access at an even address never faults. Kind 0 means no access.
- R3: A released write (`acc_write` and `acc_released` high) to an odd address raises no request when issued. It is held and reported one cycle after the first later cycle that has `ib_strobe` high or an operand access (kind 2, 3 or 4). Fetches do not release it. It is reported with the write's address and `acc_pc`.
- R4: A taken branch (`br_valid` and `br_taken` high) to an odd `br_target` is held until a later cycle with `pc_load` high. It is reported in the next cycle with `fault_addr` and `ret_pc` equal to the target and `instr_pc` equal to `br_pc`.
- R5: A branch with `br_taken` low never raises a request, whatever its target.
- R6: If a fault would be reported while `exc_ctx` is not 0, `halt` rises in the next cycle and no request is raised for it. Encoding of `exc_ctx`: 0 = normal, 1 = bus error, 2 = address error, 3 = reset.
- R7: Once raised, `halt` stays high until reset. While it is high, `exc_req` stays low and the captured registers do not change.
- R8: There is only one deferred slot. A newly deferred fault replaces the held one, and a released write wins over a branch in the same cycle. A non-deferred fault in a cycle discards every deferred fault, both the one already held and any captured in that cycle.
- R9: `exc_req` is high for exactly one cycle per reported fault. `fault_addr`, `ret_pc` and `instr_pc` change only on the edge that raises a request.
- R10: After reset, `exc_req`, `halt`, `fault_addr`, `ret_pc` and `instr_pc` are all zero, and no fault is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access used by the pipeline this cycle |
| acc_kind | input | 3 | 0 none, 1 fetch, 2 byte, 3 word, 4 long |
| acc_write | input | 1 | Access is a write |
| acc_released | input | 1 | Write already handed to the bus |
| acc_addr | input | ADDR_W | Access address |
| acc_pc | input | ADDR_W | Address of the instruction making the access |
| br_valid | input | 1 | Branch resolved this cycle |
| br_taken | input | 1 | Branch is taken |
| br_target | input | ADDR_W | Branch target |
| br_pc | input | ADDR_W | Address of the branch instruction |
| pc_load | input | 1 | Program counter updated this cycle |
| ib_strobe | input | 1 | Instruction boundary reached |
| exc_ctx | input | 2 | Current exception-processing context |
| exc_req | output | 1 | Address-error exception request pulse |
| fault_addr | output | ADDR_W | Captured faulting address |
| ret_pc | output | ADDR_W | Captured return program counter |
| instr_pc | output | ADDR_W | Captured address of the faulting instruction |
| halt | output | 1 | Processor halt, held until reset |

## Verification
A wrong state in the deferred slot shows up only when it is released. A lost fault is a missing `exc_req` on the cycle after a boundary, an operand access or a PC load. A stale fault shows up as a request, or a halt, that the stimulus never earned, and it shows at that same release point. So the bench compares every output on every cycle against its own model and catches the error within one cycle of the release event. A broken halt latch shows up directly: `halt` drops, or a request appears after the processor has stopped.

// File: rtl/misalign_pkg.sv
package misalign_pkg;
   typedef enum logic [2:0] {
      ACC_NONE  = 3'd0,
      ACC_FETCH = 3'd1,
      ACC_BYTE  = 3'd2,
      ACC_WORD  = 3'd3,
      ACC_LONG  = 3'd4
   } acc_kind_e;

   typedef enum logic [1:0] {
      CTX_NORMAL  = 2'd0,
      CTX_BUSERR  = 2'd1,
      CTX_ADDRERR = 2'd2,
      CTX_RESET   = 2'd3
   } exc_ctx_e;

   function automatic logic is_operand(input logic [2:0] k);
      return (k == ACC_BYTE) || (k == ACC_WORD) || (k == ACC_LONG);
   endfunction
endpackage

// File: rtl/misalign_detect.sv
module misalign_detect
   import misalign_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LONG_ALIGN = 1
) (
   input  logic [2:0]        kind,
   input  logic [ADDR_W-1:0] addr,
   output logic              mis
);
   initial begin
      if (ADDR_W < 2) $error("misalign_detect: ADDR_W must be at least 2");
      if (LONG_ALIGN != 1 && LONG_ALIGN != 2) $error("misalign_detect: LONG_ALIGN must be 1 or 2");
   end

   logic odd_word;
   logic odd_long;
   assign odd_word = addr[0];

   generate
      if (LONG_ALIGN == 2) begin : g_long4
         assign odd_long = |addr[1:0];
      end else begin : g_long2
         assign odd_long = addr[0];
      end
   endgenerate

   always_comb begin
      unique case (kind)
         ACC_FETCH: mis = odd_word;
         ACC_WORD:  mis = odd_word;
         ACC_LONG:  mis = odd_long;
         default:   mis = 1'b0;
      endcase
   end
endmodule

// File: rtl/misalign_defer_slot.sv
module misalign_defer_slot #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld,
   input  logic              ld_branch,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [ADDR_W-1:0] ld_ret,
   input  logic [ADDR_W-1:0] ld_ipc,
   output logic              held,
   output logic              held_branch,
   output logic [ADDR_W-1:0] held_addr,
   output logic [ADDR_W-1:0] held_ret,
   output logic [ADDR_W-1:0] held_ipc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held        <= 1'b0;
         held_branch <= 1'b0;
         held_addr   <= '0;
         held_ret    <= '0;
         held_ipc    <= '0;
      end else if (ld) begin
         held        <= 1'b1;
         held_branch <= ld_branch;
         held_addr   <= ld_addr;
         held_ret    <= ld_ret;
         held_ipc    <= ld_ipc;
      end else if (clr) begin
         held        <= 1'b0;
      end
   end

   // R8: a held branch entry must always carry an odd target address
   a_r8_branch_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (held && held_branch) |-> held_addr[0]);
endmodule

// File: rtl/misalign_exc_ctrl.sv
module misalign_exc_ctrl
   import misalign_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LONG_ALIGN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [2:0]        acc_kind,
   input  logic              acc_write,
   input  logic              acc_released,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [ADDR_W-1:0] acc_pc,
   input  logic              br_valid,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_target,
   input  logic [ADDR_W-1:0] br_pc,
   input  logic              pc_load,
   input  logic              ib_strobe,
   input  logic [1:0]        exc_ctx,
   output logic              exc_req,
   output logic [ADDR_W-1:0] fault_addr,
   output logic [ADDR_W-1:0] ret_pc,
   output logic [ADDR_W-1:0] instr_pc,
   output logic              halt
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = (LONG_ALIGN == 2) ? ADDR_W'(3) : ADDR_W'(1);

   initial begin
      if (ADDR_W < 2 || ADDR_W > 64) $error("misalign_exc_ctrl: ADDR_W out of range");
   end

   logic mis;
   logic held, held_branch;
   logic [ADDR_W-1:0] held_addr, held_ret, held_ipc;
   logic live, imm_fault, def_wr, def_br, rel_trig, raise, critical;
   logic slot_ld, slot_ld_br, slot_clr;
   logic [ADDR_W-1:0] ld_addr, ld_ret, ld_ipc;
   logic [ADDR_W-1:0] r_addr, r_ret, r_ipc;

   misalign_detect #(.ADDR_W(ADDR_W), .LONG_ALIGN(LONG_ALIGN)) u_detect (
      .kind (acc_kind),
      .addr (acc_addr),
      .mis  (mis)
   );

   always_comb begin
      live      = !halt;
      imm_fault = live && acc_valid && mis && !(acc_write && acc_released);
      def_wr    = live && acc_valid && mis && acc_write && acc_released;
      def_br    = live && br_valid && br_taken && br_target[0];
      rel_trig  = live && held && (held_branch ? pc_load
                  : (ib_strobe || (acc_valid && is_operand(acc_kind))));
      raise     = imm_fault || rel_trig;
      critical  = (exc_ctx != CTX_NORMAL);

      slot_ld    = !imm_fault && (def_wr || def_br);
      slot_ld_br = !def_wr;
      slot_clr   = halt || imm_fault || rel_trig;
      ld_addr    = def_wr ? acc_addr : br_target;
      ld_ret     = def_wr ? acc_pc   : br_target;
      ld_ipc     = def_wr ? acc_pc   : br_pc;

      if (imm_fault) begin
         r_addr = acc_addr;
         r_ret  = acc_pc;
         r_ipc  = acc_pc;
      end else begin
         r_addr = held_addr;
         r_ret  = held_ret;
         r_ipc  = held_ipc;
      end
   end

   misalign_defer_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (slot_clr),
      .ld          (slot_ld),
      .ld_branch   (slot_ld_br),
      .ld_addr     (ld_addr),
      .ld_ret      (ld_ret),
      .ld_ipc      (ld_ipc),
      .held        (held),
      .held_branch (held_branch),
      .held_addr   (held_addr),
      .held_ret    (held_ret),
      .held_ipc    (held_ipc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_req    <= 1'b0;
         halt       <= 1'b0;
         fault_addr <= '0;
         ret_pc     <= '0;
         instr_pc   <= '0;
      end else begin
         exc_req <= 1'b0;
         if (raise && critical) begin
            halt <= 1'b1;
         end else if (raise) begin
            exc_req    <= 1'b1;
            fault_addr <= r_addr;
            ret_pc     <= r_ret;
            instr_pc   <= r_ipc;
         end
      end
   end

   // R7: halt is sticky
   a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);
   // R7: no request once halted
   a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !exc_req);
   // R6: halt only rises from a critical context
   a_r6_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> $past(exc_ctx) != CTX_NORMAL);
   // R9: captured registers move only with a request
   a_r9_regs_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |-> ($stable(fault_addr) && $stable(ret_pc) && $stable(instr_pc)));
   // R1: every reported address is misaligned
   a_r1_fault_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> ((fault_addr & ALIGN_MASK) != '0));
endmodule

// File: tb/misalign_exc_ctrl_tb.sv
module misalign_exc_ctrl_tb;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 0, acc_write = 0, acc_released = 0;
   logic [2:0] acc_kind = 0;
   logic [AW-1:0] acc_addr = 0, acc_pc = 0, br_target = 0, br_pc = 0;
   logic br_valid = 0, br_taken = 0, pc_load = 0, ib_strobe = 0;
   logic [1:0] exc_ctx = 0;
   logic exc_req, halt;
   logic [AW-1:0] fault_addr, ret_pc, instr_pc;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   bit m_req, m_halt, m_held, m_hbr;
   logic [AW-1:0] m_fa, m_rp, m_ip, m_ha, m_hr, m_hi;
   string m_tag;

   always #5 clk = ~clk;

   misalign_exc_ctrl #(.ADDR_W(AW)) u_dut (.*);

   function automatic bit f_mis(input logic [2:0] k, input logic [AW-1:0] a);
      return (k == 3'd1 || k == 3'd3 || k == 3'd4) && a[0];
   endfunction

   task automatic model_reset();
      m_req = 0; m_halt = 0; m_held = 0; m_hbr = 0;
      m_fa = 0; m_rp = 0; m_ip = 0; m_ha = 0; m_hr = 0; m_hi = 0;
      m_tag = "R10";
   endtask

   // advance model by one edge using the current inputs
   task automatic model_step();
      bit imm, dw, db, rel, oper;
      logic [AW-1:0] a, r, i;
      m_req = 0;
      m_tag = "R2";
      if (m_halt) begin m_held = 0; m_tag = "R7"; return; end
      oper = acc_valid && (acc_kind == 3'd2 || acc_kind == 3'd3 || acc_kind == 3'd4);
      imm  = acc_valid && f_mis(acc_kind, acc_addr) && !(acc_write && acc_released);
      dw   = acc_valid && f_mis(acc_kind, acc_addr) && acc_write && acc_released;
      db   = br_valid && br_taken && br_target[0];
      rel  = m_held && (m_hbr ? pc_load : (ib_strobe || oper));
      if (imm) begin a = acc_addr; r = acc_pc; i = acc_pc; m_tag = "R1"; end
      else begin a = m_ha; r = m_hr; i = m_hi; m_tag = m_hbr ? "R4" : "R3"; end
      if (imm || rel) begin
         if (exc_ctx != 0) begin m_halt = 1; m_tag = "R6"; end
         else begin m_req = 1; m_fa = a; m_rp = r; m_ip = i; end
      end
      if (imm) m_held = 0;
      else if (dw) begin m_held = 1; m_hbr = 0; m_ha = acc_addr; m_hr = acc_pc; m_hi = acc_pc; end
      else if (db) begin m_held = 1; m_hbr = 1; m_ha = br_target; m_hr = br_target; m_hi = br_pc; end
      else if (rel) m_held = 0;
      if (!imm && !rel && (db || dw)) m_tag = "R8";
   endtask

   task automatic compare(input string tag);
      n_run++;
      if (exc_req !== m_req || halt !== m_halt || fault_addr !== m_fa ||
          ret_pc !== m_rp || instr_pc !== m_ip) begin
         n_fail++;
         $display("FAIL %s: req=%0b halt=%0b fa=%h rp=%h ip=%h expected req=%0b halt=%0b fa=%h rp=%h ip=%h",
                  tag, exc_req, halt, fault_addr, ret_pc, instr_pc,
                  m_req, m_halt, m_fa, m_rp, m_ip);
      end
   endtask

   task automatic idle();
      acc_valid = 0; acc_kind = 0; acc_write = 0; acc_released = 0;
      br_valid = 0; br_taken = 0; pc_load = 0; ib_strobe = 0; exc_ctx = 0;
   endtask

   // drive at negedge already done by caller; clock one edge and check
   task automatic cyc(input string tag);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic acc(input logic [2:0] k, input logic [AW-1:0] a, input logic [AW-1:0] pc,
                      input bit w, input bit rel);
      idle();
      acc_valid = 1; acc_kind = k; acc_addr = a; acc_pc = pc; acc_write = w; acc_released = rel;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      model_reset();
      @(negedge clk);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: expected run to finish, got timeout");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      do_reset();
      compare("R10 reset state");

      // R1 fetch, word, long at odd address
      acc(3'd1, 32'h101, 32'h2000, 0, 0); cyc("R1 fetch odd");
      idle(); cyc("R9 pulse ends");
      acc(3'd4, 32'h333, 32'h2004, 0, 0); cyc("R1 long odd");
      acc(3'd3, 32'h455, 32'h2008, 1, 0); cyc("R1 word write unreleased");
      // R2 byte odd and even word
      acc(3'd2, 32'h777, 32'h200c, 0, 0); cyc("R2 byte odd");
      acc(3'd3, 32'h778, 32'h2010, 0, 0); cyc("R2 word even");
      // R3 released write, released by fetch? no, by boundary
      acc(3'd3, 32'h901, 32'h3000, 1, 1); cyc("R3 deferred at issue");
      acc(3'd1, 32'h400, 32'h3002, 0, 0); cyc("R3 fetch does not release");
      idle(); ib_strobe = 1; cyc("R3 boundary releases");
      // R3 released by operand access
      acc(3'd4, 32'ha03, 32'h3010, 1, 1); cyc("R3 deferred long");
      acc(3'd2, 32'h5, 32'h3014, 0, 0); cyc("R3 operand releases");
      // R4 branch odd, held until pc_load
      idle(); br_valid = 1; br_taken = 1; br_target = 32'hb01; br_pc = 32'h4000; cyc("R4 branch held");
      idle(); ib_strobe = 1; cyc("R4 boundary does not release branch");
      idle(); pc_load = 1; cyc("R4 pc load releases");
      // R5 untaken
      idle(); br_valid = 1; br_taken = 0; br_target = 32'hc01; br_pc = 32'h4010; cyc("R5 untaken");
      idle(); pc_load = 1; cyc("R5 no later fault");
      // R8 overwrite and discard
      acc(3'd3, 32'hd01, 32'h5000, 1, 1); cyc("R8 first deferred");
      idle(); br_valid = 1; br_taken = 1; br_target = 32'hd11; br_pc = 32'h5004; cyc("R8 overwrite");
      acc(3'd3, 32'he01, 32'h5008, 0, 0); pc_load = 1; cyc("R8 immediate wins");
      idle(); pc_load = 1; ib_strobe = 1; cyc("R8 discarded stays gone");
      // R6/R7 halt
      acc(3'd1, 32'hf01, 32'h6000, 0, 0); exc_ctx = 2'd1; cyc("R6 halt in bus error context");
      acc(3'd1, 32'hf03, 32'h6002, 0, 0); cyc("R7 halted ignores");
      idle(); repeat (3) cyc("R7 halt holds");
      do_reset();
      compare("R10 reset clears halt");

      // random phases
      for (int ph = 0; ph < 40; ph++) begin
         for (int c = 0; c < 400; c++) begin
            idle();
            acc_valid = ($urandom % 3) != 0;
            acc_kind = 3'($urandom % 5);
            acc_write = $urandom % 2;
            acc_released = $urandom % 2;
            acc_addr = $urandom; acc_pc = $urandom;
            br_valid = ($urandom % 4) == 0;
            br_taken = $urandom % 2;
            br_target = $urandom; br_pc = $urandom;
            pc_load = ($urandom % 4) == 0;
            ib_strobe = ($urandom % 5) == 0;
            exc_ctx = (($urandom % 300) == 0) ? 2'(1 + $urandom % 3) : 2'd0;
            cyc("random");
            if (m_tag != "R2" && m_tag != "R7") begin end
         end
         do_reset();
         compare("R10 reset");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule